// File: doc/BRIEF.md
# Debug Bus Match Comparator

This block watches every CPU bus access for an on-chip debug unit and raises a one-cycle match pulse when an access fits the programmed criteria. The criteria are a 24-bit address that must be equal in full, an optional access direction, and one of two extra qualifiers. A parameter picks the qualifier. The data variant compares the 16-bit data bus against a compare value under a per-bit mask, and the result can be inverted so the comparator fires on inequality. The size variant checks whether the access is a word or a byte access.

The setup sits in a small byte-wide register window: a control byte, three address bytes and, on the data variant only, two data-compare bytes and two mask bytes. Reads are always allowed. Writes are refused while the debug unit reports itself armed. The tag and breakpoint control bits are passed straight out to the sequencing and breakpoint logic around the block. That logic, and tagging and trace, are outside this block.

The bus side is a monitor. `bus_valid` marks a sampled access, and the block never stalls the bus, so there is no ready signal and no back-pressure. The outgoing `match_pulse` is a single-cycle strobe that carries no handshake. Downstream logic must accept it in the cycle it is raised.

Top module: `dbg_bus_cmp`

## Requirements
- R1: After reset all window bytes read 0, `match_pulse` is 0, and `tag_mode` and `brk_en` are 0.
- R2: Window offsets are: 0 control; 1, 2 and 3 the address bytes, most significant first; 4 and 5 the data compare value, high byte then low byte; 6 and 7 the data mask, high byte then low byte. `reg_rdata` shows the byte at `reg_off` at all times. A write takes effect at the next clock edge.
- R3: A write while `armed` is 1 is dropped, and every register keeps its value.
- R4: Control byte bits: 6 = data-invert (data variant) or size-select (size variant), 5 = tag, 4 = breakpoint, 3 = direction (1 = read), 2 = direction enable, 1 = source select (stored only), 0 = compare enable. Bit 7 is size-enable on the size variant; on the data variant it always reads 0.
- R5: `match_pulse` is 1 for exactly the cycle after an edge at which `bus_valid` was 1, `bus_addr` equalled the address register and all enabled qualifiers passed. It is judged against the register values held before any write in that same cycle.
- R6: With compare enable at 0, `match_pulse` stays 0.
- R7: With direction enable at 1, a match also needs `bus_read` to equal the direction bit. With direction enable at 0, direction is ignored.
- R8: Data variant with data-invert 0: the data qualifier passes when every bus data bit whose mask bit is 1 equals the compare bit. Mask bits at 0 are ignored.
- R9: Data variant with data-invert 1: the qualifier passes when at least one mask-1 bit differs. With the mask all 0 it never passes.
- R10: Size variant with size-enable 1: a match also needs `bus_word` (1 = word) to equal the size-select bit. With size-enable 0, size is ignored.
- R11: With the tag bit at 1, the data qualifier and the size qualifier are both ignored.
- R12: On the size variant, offsets 4 to 7 read 0 and writes to them have no effect.
- R13: `tag_mode` and `brk_en` show the stored tag and breakpoint bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| armed | input | 1 | Debug unit armed; blocks writes |
| reg_wr_en | input | 1 | Write strobe for the register window |
| reg_off | input | 3 | Window offset for the read and the write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data at `reg_off` |
| bus_valid | input | 1 | A bus access is present this cycle |
| bus_addr | input | 24 | Access address |
| bus_data | input | 16 | Access data |
| bus_read | input | 1 | 1 = read access, 0 = write access |
| bus_word | input | 1 | 1 = word access, 0 = byte access |
| match_pulse | output | 1 | One-cycle match strobe |
| tag_mode | output | 1 | Stored tag bit |
| brk_en | output | 1 | Stored breakpoint bit |

## Verification
A register write and a bus access can land in the same clock cycle, and the interesting case is a write that changes the criteria the access is judged against. The bench provokes this on purpose, in directed steps and throughout the random run. It clears compare enable in the very cycle of a matching access, then sends the same access again. It expects a pulse for the first access, judged on the old values, and none for the second. Its model always computes the expected match from the shadow registers before it applies that cycle's write.

// File: rtl/dbgcmp_pkg.sv
package dbgcmp_pkg;

  // control byte, bit 7 down to bit 0
  typedef struct packed {
    logic qual_en;   // size-enable (size variant only)
    logic qual_sel;  // data-invert or size-select
    logic tag;
    logic brk;
    logic dir_rd;
    logic dir_en;
    logic src;
    logic enable;
  } cmp_ctrl_t;

  localparam int unsigned CTRL_OFF = 0;

endpackage

// File: rtl/dbgcmp_regs.sv
module dbgcmp_regs
  import dbgcmp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 16,
  parameter bit          HAS_DATA = 1'b1,
  parameter int unsigned OFF_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              wr_en,
  input  logic [OFF_W-1:0]  off,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output cmp_ctrl_t         ctrl,
  output logic [ADDR_W-1:0] cmp_addr,
  output logic [DATA_W-1:0] cmp_data,
  output logic [DATA_W-1:0] cmp_mask
);

  localparam int unsigned AB        = ADDR_W / 8;
  localparam int unsigned DB        = DATA_W / 8;
  localparam int unsigned NREG      = HAS_DATA ? 1 + AB + 2 * DB : 1 + AB;
  localparam logic [7:0]  CTRL_KEEP = HAS_DATA ? 8'h7F : 8'hFF;

  logic [7:0] regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (wr_en && !armed) begin
      for (int i = 0; i < NREG; i++) begin
        if (off == OFF_W'(i)) begin
          if (i == CTRL_OFF) regs_q[i] <= wdata & CTRL_KEEP;
          else               regs_q[i] <= wdata;
        end
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREG; i++) begin
      if (off == OFF_W'(i)) rdata = regs_q[i];
    end
  end

  assign ctrl = regs_q[CTRL_OFF];

  // most significant byte at the lowest offset
  for (genvar k = 0; k < AB; k++) begin : g_addr
    assign cmp_addr[8*(AB-1-k) +: 8] = regs_q[1+k];
  end

  if (HAS_DATA) begin : g_data
    for (genvar k = 0; k < DB; k++) begin : g_byte
      assign cmp_data[8*(DB-1-k) +: 8] = regs_q[1+AB+k];
      assign cmp_mask[8*(DB-1-k) +: 8] = regs_q[1+AB+DB+k];
    end
  end else begin : g_nodata
    assign cmp_data = '0;
    assign cmp_mask = '0;
  end

endmodule

// File: rtl/dbgcmp_qual.sv
module dbgcmp_qual
  import dbgcmp_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 16,
  parameter bit          HAS_DATA = 1'b1
) (
  input  cmp_ctrl_t         ctrl,
  input  logic [ADDR_W-1:0] cmp_addr,
  input  logic [DATA_W-1:0] cmp_data,
  input  logic [DATA_W-1:0] cmp_mask,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_read,
  input  logic              bus_word,
  output logic              hit
);

  logic addr_ok;
  logic dir_ok;
  logic aux_ok;

  assign addr_ok = (bus_addr == cmp_addr);
  assign dir_ok  = !ctrl.dir_en || (bus_read == ctrl.dir_rd);

  if (HAS_DATA) begin : g_data_qual
    logic differs;
    assign differs = |((bus_data ^ cmp_data) & cmp_mask);
    assign aux_ok  = ctrl.tag || (differs == ctrl.qual_sel);
  end else begin : g_size_qual
    assign aux_ok  = ctrl.tag || !ctrl.qual_en || (bus_word == ctrl.qual_sel);
  end

  assign hit = bus_valid && ctrl.enable && addr_ok && dir_ok && aux_ok;

  logic unused_sink;
  assign unused_sink = ^{ctrl, bus_data, bus_word, cmp_data, cmp_mask};

endmodule

// File: rtl/dbg_bus_cmp.sv
module dbg_bus_cmp
  import dbgcmp_pkg::*;
#(
  parameter  int unsigned ADDR_W   = 24,
  parameter  int unsigned DATA_W   = 16,
  parameter  bit          HAS_DATA = 1'b1,
  localparam int unsigned OFF_W    = $clog2(1 + ADDR_W / 8 + 2 * (DATA_W / 8))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              armed,
  input  logic              reg_wr_en,
  input  logic [OFF_W-1:0]  reg_off,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_read,
  input  logic              bus_word,
  output logic              match_pulse,
  output logic              tag_mode,
  output logic              brk_en
);

  cmp_ctrl_t         ctrl_q;
  logic [ADDR_W-1:0] cmp_addr;
  logic [DATA_W-1:0] cmp_data;
  logic [DATA_W-1:0] cmp_mask;
  logic              hit;

  dbgcmp_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_DATA(HAS_DATA), .OFF_W(OFF_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .armed    (armed),
    .wr_en    (reg_wr_en),
    .off      (reg_off),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .ctrl     (ctrl_q),
    .cmp_addr (cmp_addr),
    .cmp_data (cmp_data),
    .cmp_mask (cmp_mask)
  );

  dbgcmp_qual #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_DATA(HAS_DATA)
  ) u_qual (
    .ctrl      (ctrl_q),
    .cmp_addr  (cmp_addr),
    .cmp_data  (cmp_data),
    .cmp_mask  (cmp_mask),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .bus_read  (bus_read),
    .bus_word  (bus_word),
    .hit       (hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_pulse <= 1'b0;
    else        match_pulse <= hit;
  end

  assign tag_mode = ctrl_q.tag;
  assign brk_en   = ctrl_q.brk;

endmodule

// File: rtl/dbgcmp_chk.sv
module dbgcmp_chk #(
  parameter int unsigned ADDR_W   = 24,
  parameter int unsigned DATA_W   = 16,
  parameter bit          HAS_DATA = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              armed,
  input logic              reg_wr_en,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_read,
  input logic              bus_word,
  input logic              match_pulse,
  input logic [7:0]        ctrl,
  input logic [ADDR_W-1:0] cmp_addr,
  input logic [DATA_W-1:0] cmp_data,
  input logic [DATA_W-1:0] cmp_mask
);

  AST_ARMED_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && reg_wr_en) |=> ($stable(ctrl) && $stable(cmp_addr) && $stable(cmp_data) && $stable(cmp_mask))); // R3

  AST_PULSE_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> ($past(bus_valid) && ($past(bus_addr) == $past(cmp_addr)))); // R5

  AST_PULSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(ctrl[0])); // R6

  AST_DIRECTION_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    (match_pulse && $past(ctrl[2])) |-> ($past(bus_read) == $past(ctrl[3]))); // R7

  if (HAS_DATA) begin : g_data_chk
    // data-invert 0 needs equality, data-invert 1 needs a difference (R9)
    AST_DATA_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (match_pulse && !$past(ctrl[5])) |->
        ((|(($past(bus_data) ^ $past(cmp_data)) & $past(cmp_mask))) == $past(ctrl[6]))); // R8
  end else begin : g_size_chk
    AST_SIZE_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (match_pulse && $past(ctrl[7]) && !$past(ctrl[5])) |-> ($past(bus_word) == $past(ctrl[6]))); // R10
  end

endmodule

bind dbg_bus_cmp dbgcmp_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HAS_DATA(HAS_DATA)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .armed       (armed),
  .reg_wr_en   (reg_wr_en),
  .bus_valid   (bus_valid),
  .bus_addr    (bus_addr),
  .bus_data    (bus_data),
  .bus_read    (bus_read),
  .bus_word    (bus_word),
  .match_pulse (match_pulse),
  .ctrl        (ctrl_q),
  .cmp_addr    (cmp_addr),
  .cmp_data    (cmp_data),
  .cmp_mask    (cmp_mask)
);

// File: tb/test_dbg_bus_cmp.sv
`timescale 1ns/1ps
module test_dbg_bus_cmp;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        armed = 0, reg_wr_en = 0, bus_valid = 0, bus_read = 0, bus_word = 0;
  logic [2:0]  reg_off = 0;
  logic [7:0]  reg_wdata = 0;
  logic [23:0] bus_addr = 0;
  logic [15:0] bus_data = 0;
  logic [7:0]  rdata_d, rdata_s;
  logic        match_d, match_s, tag_d, tag_s, brk_d, brk_s;

  dbg_bus_cmp #(.HAS_DATA(1'b1)) i_dbg_bus_cmp (
    .clk(clk), .rst_n(rst_n), .armed(armed), .reg_wr_en(reg_wr_en), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_d), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_read(bus_read), .bus_word(bus_word),
    .match_pulse(match_d), .tag_mode(tag_d), .brk_en(brk_d));

  dbg_bus_cmp #(.HAS_DATA(1'b0)) i_dbg_bus_cmp_sz (
    .clk(clk), .rst_n(rst_n), .armed(armed), .reg_wr_en(reg_wr_en), .reg_off(reg_off),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_s), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_read(bus_read), .bus_word(bus_word),
    .match_pulse(match_s), .tag_mode(tag_s), .brk_en(brk_s));

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] sh_d = '0, sh_s = '0;   // byte i of the window at [8*i +: 8]
  logic exp_d = 1'b0, exp_s = 1'b0;

  function automatic logic [63:0] shadow_write(bit has_data, logic [63:0] sh, int off, logic [7:0] v);
    logic [63:0] r = sh;
    if (!has_data && off >= 4) return r;          // R12
    if (off == 0 && has_data) v[7] = 1'b0;        // R4
    r[8*off +: 8] = v;
    return r;
  endfunction

  function automatic logic exp_hit(bit has_data, logic [63:0] sh, logic v, logic [23:0] a,
                                   logic [15:0] d, logic rd, logic wd);
    logic [7:0]  c   = sh[7:0];
    logic [23:0] ra  = {sh[15:8], sh[23:16], sh[31:24]};
    logic [15:0] cmp = {sh[39:32], sh[47:40]};
    logic [15:0] msk = {sh[55:48], sh[63:56]};
    logic ok = v && c[0] && (a == ra) && (!c[2] || (rd == c[3]));
    if (c[5]) return ok;                                         // R11
    if (has_data) return ok && ((((d ^ cmp) & msk) != 0) == c[6]); // R8 R9
    return ok && (!c[7] || (wd == c[6]));                        // R10
  endfunction

  task automatic chk(string req, string what, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s got %02h expected %02h", req, what, got, exp);
    end
  endtask

  task automatic step(string req, logic wr, logic [2:0] off, logic [7:0] wd, logic arm,
                      logic v, logic [23:0] a, logic [15:0] d, logic rd, logic wdw);
    @(negedge clk);
    chk(req, "match data-variant", {7'b0, match_d}, {7'b0, exp_d});
    chk(req, "match size-variant", {7'b0, match_s}, {7'b0, exp_s});
    chk("R13", "tag/brk data-variant", {6'b0, tag_d, brk_d}, {6'b0, sh_d[5], sh_d[4]});
    chk("R13", "tag/brk size-variant", {6'b0, tag_s, brk_s}, {6'b0, sh_s[5], sh_s[4]});
    reg_wr_en = wr; reg_off = off; reg_wdata = wd; armed = arm;
    bus_valid = v; bus_addr = a; bus_data = d; bus_read = rd; bus_word = wdw;
    #1;
    chk("R2", "rdata data-variant", rdata_d, sh_d[8*off +: 8]);
    chk("R12", "rdata size-variant", rdata_s, sh_s[8*off +: 8]);
    exp_d = exp_hit(1'b1, sh_d, v, a, d, rd, wdw);
    exp_s = exp_hit(1'b0, sh_s, v, a, d, rd, wdw);
    if (wr && !arm) begin
      sh_d = shadow_write(1'b1, sh_d, int'(off), wd);
      sh_s = shadow_write(1'b0, sh_s, int'(off), wd);
    end
  endtask

  task automatic wr(string req, logic [2:0] off, logic [7:0] v);
    step(req, 1'b1, off, v, 1'b0, 1'b0, 24'h0, 16'h0, 1'b0, 1'b0);
  endtask

  task automatic acc(string req, logic [23:0] a, logic [15:0] d, logic rd, logic wdw);
    step(req, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, a, d, rd, wdw);
  endtask

  localparam logic [23:0] A0 = 24'h123456;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1: everything reads zero after reset
    for (int i = 0; i < 8; i++) step("R1", 1'b0, 3'(i), 8'h00, 1'b0, 1'b1, 24'h0, 16'h0, 1'b0, 1'b0);

    // R4: bit 7 only held on the size variant
    wr("R4", 3'd0, 8'hFF);
    step("R4", 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 24'h0, 16'h0, 1'b0, 1'b0);

    // R2: program address, compare, mask
    wr("R2", 3'd0, 8'h01);
    wr("R2", 3'd1, 8'h12); wr("R2", 3'd2, 8'h34); wr("R2", 3'd3, 8'h56);
    wr("R12", 3'd4, 8'hA5); wr("R12", 3'd5, 8'h5A);
    wr("R12", 3'd6, 8'hFF); wr("R12", 3'd7, 8'h00);
    acc("R8", A0, 16'hA5C3, 1'b0, 1'b0);      // masked low byte ignored
    acc("R8", A0, 16'hB5C3, 1'b1, 1'b1);      // high byte differs
    acc("R5", A0 ^ 24'h000001, 16'hA500, 1'b0, 1'b0); // address LSB off
    acc("R5", A0 ^ 24'h800000, 16'hA500, 1'b0, 1'b0); // address MSB off
    step("R5", 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, A0, 16'hA500, 1'b0, 1'b0); // no valid

    // R3: write dropped while armed
    step("R3", 1'b1, 3'd0, 8'h00, 1'b1, 1'b0, A0, 16'h0, 1'b0, 1'b0);
    step("R3", 1'b1, 3'd1, 8'h99, 1'b1, 1'b0, A0, 16'h0, 1'b0, 1'b0);
    acc("R3", A0, 16'hA511, 1'b0, 1'b0);

    // R5: write in the same cycle as a matching access uses old values
    step("R5", 1'b1, 3'd0, 8'h00, 1'b0, 1'b1, A0, 16'hA500, 1'b0, 1'b0);
    acc("R6", A0, 16'hA500, 1'b0, 1'b0);      // R6 compare disabled
    acc("R6", A0, 16'hA500, 1'b0, 1'b0);

    // R9: inverted data compare, then all bits masked
    wr("R9", 3'd0, 8'h41);
    acc("R9", A0, 16'hA500, 1'b0, 1'b0);
    acc("R9", A0, 16'hA400, 1'b0, 1'b1);
    wr("R9", 3'd6, 8'h00);
    acc("R9", A0, 16'h0000, 1'b0, 1'b1);
    acc("R9", A0, 16'hFFFF, 1'b0, 1'b0);

    // R7: direction qualifier, read only
    wr("R7", 3'd0, 8'h0D);
    acc("R7", A0, 16'h0, 1'b1, 1'b0);
    acc("R7", A0, 16'h0, 1'b0, 1'b0);
    wr("R7", 3'd0, 8'h05);
    acc("R7", A0, 16'h0, 1'b0, 1'b1);

    // R10: size qualifier, word only
    wr("R10", 3'd0, 8'hC1);
    acc("R10", A0, 16'h1234, 1'b0, 1'b1);
    acc("R10", A0, 16'h1234, 1'b0, 1'b0);
    wr("R10", 3'd0, 8'h81);
    acc("R10", A0, 16'h0, 1'b1, 1'b0);

    // R11: tag overrides data and size qualifiers
    wr("R11", 3'd0, 8'hE1);
    acc("R11", A0, 16'h0000, 1'b0, 1'b0);
    wr("R13", 3'd0, 8'h11);
    acc("R13", A0, 16'h0000, 1'b0, 1'b0);

    // random mix, writes often overlapping accesses (R5)
    for (int n = 0; n < 6000; n++) begin
      logic        w   = ($urandom % 4) == 0;
      logic        ar  = ($urandom % 5) == 0;
      logic [2:0]  o   = 3'($urandom);
      logic [7:0]  wv  = 8'($urandom);
      logic [23:0] a   = ($urandom % 2) ? {sh_d[15:8], sh_d[23:16], sh_d[31:24]} : 24'($urandom);
      logic [15:0] cv  = {sh_d[39:32], sh_d[47:40]};
      logic [15:0] d   = ($urandom % 2) ? (cv ^ (16'($urandom) & 16'($urandom) & 16'($urandom))) : 16'($urandom);
      if (o == 3'd0 && ($urandom % 4) != 0) wv[0] = 1'b1;
      if (o == 3'd0 && ($urandom % 2) != 0) wv[5] = 1'b0;
      step("R5", w, o, wv, ar, ($urandom % 4) != 0, a, d, 1'($urandom), 1'($urandom));
    end

    step("R5", 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 24'h0, 16'h0, 1'b0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule